// File: doc/BRIEF.md
# Interrupt Exit Restore Sequencer

This block is the common exit stage of a hardware packet-filter controller. Several upstream handling stages hand over to it: those that finish a receive or transmit interrupt, and those that find an error in a received or transmitted packet. Each upstream stage raises a one-cycle entry request and presents a cause code. With the request it presents the two device registers that were saved when the interrupt was first read, and a flag that tells whether the packet was accepted by the filter.

Once the sequencer has accepted a request, it runs a fixed sequence. First it writes the saved pointer register and then the saved bank-select register back to the network controller, one write per cycle. Next, if the packet was accepted and the cause is not an error, it pulses an interrupt to the host processor. Finally it pulses a re-initialise strobe so that the upstream logic and its own captured values return to their reset state. It then goes idle and waits for the next request. A busy output stays high while the sequence runs.

Top module: `irq_exit_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after reset, `busy_o`, `reg_we_o`, `host_irq_o` and `reinit_o` are all low.
- R2: A request (`start_i` high while idle) that is sampled at a clock edge produces, in the next cycle, a write with `reg_addr_o` = PTR_ADDR (default 4'h6) and `reg_wdata_o` equal to `saved_ptr_i` as sampled at that edge.
- R3: The cycle right after the pointer write carries a write with `reg_addr_o` = BANK_ADDR (default 4'hE) and the `saved_bank_i` value sampled with the request.
- R4: Each sequence issues exactly two register writes, with the pointer write before the bank write. No two of the write strobe, the host interrupt and the re-initialise strobe are high in the same cycle.
- R5: When `accept_i` was high and `cause_i[1]` was 0 at the request (cause 2'b00 receive done, 2'b01 transmit done), `host_irq_o` is high for exactly one cycle, in the cycle after the bank write.
- R6: When `cause_i[1]` was 1 at the request (2'b10 receive error, 2'b11 transmit error), or when `accept_i` was low, no host interrupt is raised.
- R7: `reinit_o` pulses for one cycle as the last step of every sequence. It comes after the host interrupt when one is raised, and otherwise after the bank write. The cycle after it is idle.
- R8: `busy_o` is high from the cycle after the request through the re-initialise cycle: 4 cycles with a notify, 3 cycles without.
- R9: A `start_i` that arrives while busy, including in the re-initialise cycle, is ignored. It adds no writes, pulses or busy cycles.
- R10: The saved values, the cause and the accept flag are taken only with the request. Changes to them during a sequence do not alter its writes or its notify decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Entry request from an upstream stage |
| cause_i | input | 2 | Entry cause; bit 1 set means error path |
| saved_ptr_i | input | DATA_W | Pointer register value saved at interrupt read |
| saved_bank_i | input | DATA_W | Bank-select value saved at interrupt read |
| accept_i | input | 1 | Packet was accepted by the filter |
| reg_we_o | output | 1 | Register write strobe toward the network controller |
| reg_addr_o | output | ADDR_W | Register write address |
| reg_wdata_o | output | DATA_W | Register write data |
| host_irq_o | output | 1 | One-cycle interrupt to the host processor |
| reinit_o | output | 1 | One-cycle strobe to re-initialise flags and variables |
| busy_o | output | 1 | Sequence in progress |

## Verification
Two events can land on the same clock edge: a fresh entry request and the re-initialise step that ends the previous sequence. The bench provokes this by raising `start_i` exactly in the cycle where `reinit_o` is seen. The design is correct if that request starts nothing, so `busy_o` stays low and the scoreboard gets no extra write. A second case drives a new request with flipped saved values, a non-error cause and accept set while a no-notify sequence is running. Any stray host interrupt or changed write data then shows up as a scoreboard mismatch.

// File: rtl/irq_exit_pkg.sv
package irq_exit_pkg;

    // Sequencer steps, visited in this order; ST_NOTIFY is skipped when not needed.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WR_PTR  = 3'd1,
        ST_WR_BANK = 3'd2,
        ST_NOTIFY  = 3'd3,
        ST_REINIT  = 3'd4
    } exit_state_e;

    // Entry cause; the upper bit marks the error paths.
    typedef enum logic [1:0] {
        CAUSE_RX_DONE = 2'b00,
        CAUSE_TX_DONE = 2'b01,
        CAUSE_RX_ERR  = 2'b10,
        CAUSE_TX_ERR  = 2'b11
    } exit_cause_e;

    function automatic logic cause_is_error(input logic [1:0] cause);
        return cause[1];
    endfunction

endpackage

// File: rtl/exit_capture.sv
module exit_capture
    import irq_exit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              clear_i,
    input  logic [DATA_W-1:0] ptr_i,
    input  logic [DATA_W-1:0] bank_i,
    input  logic [1:0]        cause_i,
    input  logic              accept_i,
    output logic [DATA_W-1:0] ptr_o,
    output logic [DATA_W-1:0] bank_o,
    output logic              notify_o
);

    typedef struct packed {
        logic [DATA_W-1:0] ptr;
        logic [DATA_W-1:0] bank;
        logic [1:0]        cause;
        logic              accept;
    } hold_t;

    hold_t hold_d, hold_q;

    // Values are taken once at entry and wiped on the re-initialise step.
    always_comb begin
        hold_d = hold_q;
        if (load_i) begin
            hold_d.ptr    = ptr_i;
            hold_d.bank   = bank_i;
            hold_d.cause  = cause_i;
            hold_d.accept = accept_i;
        end else if (clear_i) begin
            hold_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign ptr_o    = hold_q.ptr;
    assign bank_o   = hold_q.bank;
    assign notify_o = hold_q.accept && !cause_is_error(hold_q.cause);

endmodule

// File: rtl/exit_fsm.sv
module exit_fsm
    import irq_exit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        notify_i,
    output exit_state_e state_o,
    output logic        load_o,
    output logic        clear_o
);

    typedef struct packed {
        exit_state_e state;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.state)
            ST_IDLE:    if (start_i) fsm_d.state = ST_WR_PTR;
            ST_WR_PTR:  fsm_d.state = ST_WR_BANK;
            ST_WR_BANK: fsm_d.state = notify_i ? ST_NOTIFY : ST_REINIT;
            ST_NOTIFY:  fsm_d.state = ST_REINIT;
            ST_REINIT:  fsm_d.state = ST_IDLE;
            default:    fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.state;
    // Requests are only taken while idle; any other time they are dropped.
    assign load_o  = (fsm_q.state == ST_IDLE) && start_i;
    assign clear_o = (fsm_q.state == ST_REINIT);

endmodule

// File: rtl/exit_out_decode.sv
module exit_out_decode
    import irq_exit_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PTR_ADDR  = 4'h6,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 4'hE
) (
    input  exit_state_e       state_i,
    input  logic [DATA_W-1:0] ptr_i,
    input  logic [DATA_W-1:0] bank_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              irq_o,
    output logic              reinit_o,
    output logic              busy_o
);

    // Outputs depend only on the registered step, so each is one clean cycle.
    always_comb begin
        we_o     = 1'b0;
        addr_o   = '0;
        wdata_o  = '0;
        irq_o    = 1'b0;
        reinit_o = 1'b0;
        busy_o   = (state_i != ST_IDLE);
        unique case (state_i)
            ST_WR_PTR: begin
                we_o    = 1'b1;
                addr_o  = PTR_ADDR;
                wdata_o = ptr_i;
            end
            ST_WR_BANK: begin
                we_o    = 1'b1;
                addr_o  = BANK_ADDR;
                wdata_o = bank_i;
            end
            ST_NOTIFY: irq_o    = 1'b1;
            ST_REINIT: reinit_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_exit_sequencer.sv
module irq_exit_sequencer
    import irq_exit_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PTR_ADDR  = 4'h6,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 4'hE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        cause_i,
    input  logic [DATA_W-1:0] saved_ptr_i,
    input  logic [DATA_W-1:0] saved_bank_i,
    input  logic              accept_i,
    output logic              reg_we_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              host_irq_o,
    output logic              reinit_o,
    output logic              busy_o
);

    exit_state_e       state;
    logic              load;
    logic              clear;
    logic              notify;
    logic [DATA_W-1:0] held_ptr;
    logic [DATA_W-1:0] held_bank;

    exit_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .notify_i (notify),
        .state_o  (state),
        .load_o   (load),
        .clear_o  (clear)
    );

    exit_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .clear_i  (clear),
        .ptr_i    (saved_ptr_i),
        .bank_i   (saved_bank_i),
        .cause_i  (cause_i),
        .accept_i (accept_i),
        .ptr_o    (held_ptr),
        .bank_o   (held_bank),
        .notify_o (notify)
    );

    exit_out_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PTR_ADDR  (PTR_ADDR),
        .BANK_ADDR (BANK_ADDR)
    ) u_decode (
        .state_i  (state),
        .ptr_i    (held_ptr),
        .bank_i   (held_bank),
        .we_o     (reg_we_o),
        .addr_o   (reg_addr_o),
        .wdata_o  (reg_wdata_o),
        .irq_o    (host_irq_o),
        .reinit_o (reinit_o),
        .busy_o   (busy_o)
    );

endmodule

// File: rtl/irq_exit_sequencer_chk.sv
module irq_exit_sequencer_chk #(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PTR_ADDR  = 4'h6,
    parameter logic [ADDR_W-1:0] BANK_ADDR = 4'hE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              reg_we_o,
    input logic [ADDR_W-1:0] reg_addr_o,
    input logic [DATA_W-1:0] reg_wdata_o,
    input logic              host_irq_o,
    input logic              reinit_o,
    input logic              busy_o
);

    p_entry_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && reg_we_o && reg_addr_o == PTR_ADDR));

    p_bank_follows_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_o && reg_addr_o == PTR_ADDR) |=> (reg_we_o && reg_addr_o == BANK_ADDR));

    p_one_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_we_o, host_irq_o, reinit_o}));

    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_o |=> !host_irq_o);

    p_irq_after_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq_o |-> $past(reg_we_o && reg_addr_o == BANK_ADDR));

    p_reinit_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_o |=> !busy_o);

    p_actions_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_o || host_irq_o || reinit_o) |-> busy_o);

endmodule

bind irq_exit_sequencer irq_exit_sequencer_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PTR_ADDR  (PTR_ADDR),
    .BANK_ADDR (BANK_ADDR)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .host_irq_o  (host_irq_o),
    .reinit_o    (reinit_o),
    .busy_o      (busy_o)
);

// File: tb/test_irq_exit_sequencer.sv
module test_irq_exit_sequencer;

    localparam int          ADDR_W    = 4;
    localparam int          DATA_W    = 8;
    localparam logic [3:0]  PTR_ADDR  = 4'h6;
    localparam logic [3:0]  BANK_ADDR = 4'hE;
    localparam int          K_WR = 0, K_IRQ = 1, K_CLR = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [1:0]        cause_i = 2'b00;
    logic [DATA_W-1:0] saved_ptr_i = '0;
    logic [DATA_W-1:0] saved_bank_i = '0;
    logic              accept_i = 1'b0;
    logic              reg_we_o;
    logic [ADDR_W-1:0] reg_addr_o;
    logic [DATA_W-1:0] reg_wdata_o;
    logic              host_irq_o;
    logic              reinit_o;
    logic              busy_o;

    always #10 clk = ~clk;

    irq_exit_sequencer i_irq_exit_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cause_i      (cause_i),
        .saved_ptr_i  (saved_ptr_i),
        .saved_bank_i (saved_bank_i),
        .accept_i     (accept_i),
        .reg_we_o     (reg_we_o),
        .reg_addr_o   (reg_addr_o),
        .reg_wdata_o  (reg_wdata_o),
        .host_irq_o   (host_irq_o),
        .reinit_o     (reinit_o),
        .busy_o       (busy_o)
    );

    typedef struct {
        int          kind;
        logic [31:0] word;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_obs(input int kind, input logic [3:0] a, input logic [7:0] d);
        return {kind[7:0], 12'd0, a, d};
    endfunction

    // Monitor: pops one expected item per observed action.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if ((reg_we_o + host_irq_o + reinit_o) > 1)
                chk({29'd0, reg_we_o, host_irq_o, reinit_o}, 32'd0, "R4 actions overlap");
            else if (reg_we_o || host_irq_o || reinit_o) begin
                logic [31:0] obs;
                if (reg_we_o)        obs = pack_obs(K_WR, reg_addr_o, reg_wdata_o);
                else if (host_irq_o) obs = pack_obs(K_IRQ, 4'h0, 8'h00);
                else                 obs = pack_obs(K_CLR, 4'h0, 8'h00);
                if (exp_q.size() == 0) begin
                    chk(obs, 32'hFFFF_FFFF, "R9 unexpected action");
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(obs, e.word, e.tag);
                end
            end
        end
    end

    // Driver: issue one request and push the expected actions.
    task automatic run_seq(input logic [7:0] ptr, input logic [7:0] bank,
                           input logic [1:0] cause, input logic acc,
                           input bit disturb, input bit hit_reinit);
        int  cnt;
        bit  note;
        note = acc && !cause[1];
        @(negedge clk);
        saved_ptr_i = ptr; saved_bank_i = bank; cause_i = cause; accept_i = acc;
        start_i = 1'b1;
        exp_q.push_back('{K_WR, pack_obs(K_WR, PTR_ADDR, ptr), "R2 pointer write"});
        exp_q.push_back('{K_WR, pack_obs(K_WR, BANK_ADDR, bank), "R3 bank write"});
        if (note) exp_q.push_back('{K_IRQ, pack_obs(K_IRQ, 4'h0, 8'h00), "R5 host notify"});
        exp_q.push_back('{K_CLR, pack_obs(K_CLR, 4'h0, 8'h00), note ? "R7 reinit after notify" : "R6 R7 reinit without notify"});
        @(negedge clk);
        start_i = 1'b0;
        chk({31'd0, busy_o}, 32'd1, "R8 busy after entry");
        cnt = 1;
        while (busy_o && cnt < 20) begin
            if (disturb && cnt == 1) begin
                // R10: new values mid-sequence must not be used.
                start_i = 1'b1;
                saved_ptr_i = ~ptr; saved_bank_i = ~bank; cause_i = 2'b00; accept_i = 1'b1;
            end else if (hit_reinit && reinit_o) begin
                start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            if (busy_o) cnt++;
        end
        start_i = 1'b0;
        chk(cnt, note ? 32'd4 : 32'd3, "R8 busy length");
        @(negedge clk);
        chk({31'd0, busy_o}, 32'd0, "R9 no restart after ignored start");
        chk(exp_q.size(), 32'd0, "R4 all actions seen");
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({28'd0, busy_o, reg_we_o, host_irq_o, reinit_o}, 32'd0, "R1 reset outputs");
        start_i = 1'b1; // held in reset: must be ignored
        @(negedge clk);
        start_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk({28'd0, busy_o, reg_we_o, host_irq_o, reinit_o}, 32'd0, "R1 after reset");

        run_seq(8'h3C, 8'h02, 2'b00, 1'b1, 0, 0); // rx done, accepted: R5
        run_seq(8'hA5, 8'h01, 2'b01, 1'b1, 0, 0); // tx done, accepted
        run_seq(8'h11, 8'h03, 2'b00, 1'b0, 0, 0); // rejected: R6
        run_seq(8'hF0, 8'h02, 2'b10, 1'b1, 0, 0); // rx error: R6
        run_seq(8'h7E, 8'h00, 2'b11, 1'b1, 0, 0); // tx error: R6
        run_seq(8'h5A, 8'h02, 2'b10, 1'b0, 1, 0); // disturbed mid-run: R9 R10
        run_seq(8'hC3, 8'h01, 2'b01, 1'b1, 1, 0); // disturbed with notify: R10
        run_seq(8'h99, 8'h03, 2'b00, 1'b1, 0, 1); // start in reinit cycle: R9
        run_seq(8'h00, 8'hFF, 2'b11, 1'b0, 0, 1);
        run_seq(8'hFF, 8'h00, 2'b00, 1'b1, 0, 0); // back-to-back after ignored start

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule